// File: doc/BRIEF.md
# Sequential ChaCha Double-Round Engine

This block applies the ChaCha core permutation (the twenty-round mixing used by HChaCha20) to a 16-word state of 32-bit words. It does not instantiate parallel quarter-round units. It has a single add-xor-rotate datapath and performs one element step per clock cycle. Four lookups per step choose what that step does: the word that receives the sum, the word that is added into it, the word that is xored and rotated, and the rotate amount. The first three come from a constant index table that is filled in at elaboration. The fourth comes from a four-entry rotate table, chosen by the low bits of the step number.

A caller drives the whole state on the load port and pulses start. The engine then runs the configured number of double rounds, 32 element steps each, and raises done for one cycle. The result port always shows the working state. When done is high it holds the permuted words. The input is not added back, and key, nonce and keystream handling stay outside the block.

Top module: `qr_step_core`

## Requirements
- R1: After a synchronous active-high reset, done is 0 and every bit of result is 0.
- R2: A start pulse while the engine is idle copies load_state into the state on that clock edge. Word i is bits [32i+31:32i] on both the load and result ports, and result shows the loaded words in the next cycle.
- R3: Each clock edge while running performs exactly one element step. The step first computes a = a + b (mod 2^32) and then d = rotl32(d xor new a, s). No other word changes, and each step sees every result of the step before it.
- R4: For step k of a double round (k = 0..31), the quarter round is k/4 and the position is k%4. Position 0 does a+=b and rotates d by 16. Position 1 does c+=d and rotates b by 12. Position 2 does a+=b and rotates d by 8. Position 3 does c+=d and rotates b by 7. The words taken from the quarter round (a,b,c,d) are as listed.
- R5: Steps 0 to 15 of a double round work on the grid columns, with quarter rounds (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15) in that order. Word w sits at row w/4, column w%4.
- R6: Steps 16 to 31 work on the diagonals, with quarter rounds (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14) in that order.
- R7: A run is DBL_ROUNDS double rounds (default 10, that is 320 steps). The final result is the permuted state with no feed-forward addition of the loaded words.
- R8: done is high for exactly one cycle. That cycle immediately follows the edge that performs the last step, so done is first visible DBL_ROUNDS*32 edges after the start edge. done is low at every earlier point of the run.
- R9: A start pulse while the engine is running has no effect: the state is not reloaded, the step order is not disturbed, and the end of the run is not moved. This also holds for a pulse on the edge of the final step.
- R10: While idle with start low, result holds its value. A start pulse in the cycle in which done is high is accepted as a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the words on load_state; ignored while running |
| load_state | input | 512 | Initial state, word i at bits [32i+31:32i] |
| done | output | 1 | One-cycle pulse once the last step has been applied |
| result | output | 512 | Working state, word i at bits [32i+31:32i] |

## Verification
The stepwise sweep uses several state patterns in a one-double-round build and compares the state after every single step with an arithmetic model: counting words, a dense constant-derived spread, all ones, an alternating rotated pattern, and a single set bit in one word of each row. The single-bit patterns show which words a step reads and writes, so a wrong index entry or a swapped quarter-round order shows up at the first step it affects. The dense patterns catch a wrong rotate amount or an xor taken before the add. Full ten-double-round runs check the final permutation, the exact cycle of done, start pulses in the middle of a run and on its last edge, and a restart issued in the done cycle.

// File: rtl/qrs_pkg.sv
`timescale 1ns/1ps
package qrs_pkg;

    localparam int WORD_W       = 32;
    localparam int NUM_WORDS    = 16;
    localparam int GRID_DIM     = 4;
    localparam int STATE_W      = NUM_WORDS * WORD_W;
    localparam int IDX_W        = $clog2(NUM_WORDS);
    localparam int STEPS_PER_QR = 4;
    localparam int QR_PER_DR    = 2 * GRID_DIM;
    localparam int STEPS_PER_DR = STEPS_PER_QR * QR_PER_DR;
    localparam int STEP_W       = $clog2(STEPS_PER_DR);
    localparam int SUB_W        = $clog2(STEPS_PER_QR);
    localparam int ROT_W        = $clog2(WORD_W);

    // Role of a word inside one quarter round; also its grid row.
    localparam int ROLE_A = 0;
    localparam int ROLE_B = 1;
    localparam int ROLE_C = 2;
    localparam int ROLE_D = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [ROT_W-1:0]  rot_amt_t;
    typedef logic [SUB_W-1:0]  rot_sel_t;

    // Control word for one element step: the four lookups.
    typedef struct packed {
        widx_t    add_dst;
        widx_t    add_src;
        widx_t    rot_tgt;
        rot_sel_t rot_sel;
    } step_ctl_t;

    // Word index of a role within quarter round qr.
    // Quarter rounds below GRID_DIM walk columns, the rest walk diagonals.
    function automatic widx_t qr_member(input int unsigned qr, input int unsigned role);
        int unsigned lane;
        int unsigned col;
        lane = qr % GRID_DIM;
        if (qr < GRID_DIM) col = lane;
        else               col = (lane + role) % GRID_DIM;
        return widx_t'(role * GRID_DIM + col);
    endfunction

    // Table entry for step k of a double round.
    function automatic step_ctl_t step_ctl(input int unsigned k);
        step_ctl_t   c;
        int unsigned qr;
        int unsigned sub;
        qr  = k / STEPS_PER_QR;
        sub = k % STEPS_PER_QR;
        if ((sub % 2) == 0) begin
            c.add_dst = qr_member(qr, ROLE_A);
            c.add_src = qr_member(qr, ROLE_B);
            c.rot_tgt = qr_member(qr, ROLE_D);
        end else begin
            c.add_dst = qr_member(qr, ROLE_C);
            c.add_src = qr_member(qr, ROLE_D);
            c.rot_tgt = qr_member(qr, ROLE_B);
        end
        c.rot_sel = rot_sel_t'(sub);
        return c;
    endfunction

    // Rotate amount for a position inside the quarter round.
    function automatic rot_amt_t rot_amount(input int unsigned sel);
        case (sel % STEPS_PER_QR)
            0:       return rot_amt_t'(16);
            1:       return rot_amt_t'(12);
            2:       return rot_amt_t'(8);
            default: return rot_amt_t'(7);
        endcase
    endfunction

    function automatic word_t rotl(input word_t v, input rot_amt_t s);
        logic [2*WORD_W-1:0] dbl;
        dbl = {v, v} >> (WORD_W - int'(s));
        return dbl[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/qrs_step_rom.sv
`timescale 1ns/1ps
module qrs_step_rom import qrs_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [STEP_W-1:0] step_idx,
    output step_ctl_t         ctl
);

    step_ctl_t tbl [STEPS_PER_DR];

    for (genvar k = 0; k < STEPS_PER_DR; k++) begin : g_tbl
        assign tbl[k] = step_ctl(k);
    end

    assign ctl = tbl[step_idx];

    // R3: the three word lookups of a step never collide
    p_distinct_idx_r3: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (ctl.add_dst != ctl.add_src) &&
                    (ctl.add_dst != ctl.rot_tgt) &&
                    (ctl.add_src != ctl.rot_tgt));

    // R4: consecutive steps inside a quarter round advance the rotate selector
    p_rot_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        step_en && (step_idx[SUB_W-1:0] != '0) |-> ctl.rot_sel == step_idx[SUB_W-1:0]);

endmodule

// File: rtl/qrs_datapath.sv
`timescale 1ns/1ps
module qrs_datapath import qrs_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic [STATE_W-1:0] load_vec,
    input  logic               step_en,
    input  step_ctl_t          ctl,
    output logic [STATE_W-1:0] state_vec
);

    word_t    st [NUM_WORDS];
    rot_amt_t rot_tbl [STEPS_PER_QR];
    rot_amt_t amt;
    word_t    sum_w;
    word_t    mix_w;
    word_t    rot_w;

    for (genvar j = 0; j < STEPS_PER_QR; j++) begin : g_rot
        assign rot_tbl[j] = rot_amount(j);
    end

    // Fused step: the xor reads the fresh sum, not the stored word.
    always_comb begin
        amt   = rot_tbl[ctl.rot_sel];
        sum_w = st[ctl.add_dst] + st[ctl.add_src];
        mix_w = st[ctl.rot_tgt] ^ sum_w;
        rot_w = rotl(mix_w, amt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) st[i] <= '0;
        end else if (load_en) begin
            for (int i = 0; i < NUM_WORDS; i++) st[i] <= load_vec[i*WORD_W +: WORD_W];
        end else if (step_en) begin
            st[ctl.add_dst] <= sum_w;
            st[ctl.rot_tgt] <= rot_w;
        end
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        assign state_vec[i*WORD_W +: WORD_W] = st[i];

        // R3: words outside the current step keep their value
        p_untouched_r3: assert property (@(posedge clk) disable iff (rst)
            step_en && !load_en && (ctl.add_dst != widx_t'(i)) && (ctl.rot_tgt != widx_t'(i))
            |=> $stable(st[i]));

        // R2: a load places each word at its own slice
        p_load_word_r2: assert property (@(posedge clk) disable iff (rst)
            load_en |=> st[i] == $past(load_vec[i*WORD_W +: WORD_W]));

        // R10: with neither load nor step the state holds
        p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
            !load_en && !step_en |=> $stable(st[i]));
    end

endmodule

// File: rtl/qrs_sequencer.sv
`timescale 1ns/1ps
module qrs_sequencer import qrs_pkg::*; #(
    parameter int DBL_ROUNDS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              load_en,
    output logic              step_en,
    output logic [STEP_W-1:0] step_idx,
    output logic              done
);

    localparam int RND_W       = (DBL_ROUNDS > 1) ? $clog2(DBL_ROUNDS) : 1;
    localparam int TOTAL_STEPS = DBL_ROUNDS * STEPS_PER_DR;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS_PER_DR - 1);
    localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(DBL_ROUNDS - 1);

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

    seq_state_e        st_q;
    logic [STEP_W-1:0] step_q;
    logic [RND_W-1:0]  rnd_q;
    logic              done_q;
    logic              last_step;

    assign load_en   = start && (st_q == SEQ_IDLE);
    assign step_en   = (st_q == SEQ_RUN);
    assign step_idx  = step_q;
    assign done      = done_q;
    assign last_step = (step_q == LAST_STEP) && (rnd_q == LAST_RND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            step_q <= '0;
            rnd_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                SEQ_IDLE: begin
                    if (start) begin
                        st_q   <= SEQ_RUN;
                        step_q <= '0;
                        rnd_q  <= '0;
                    end
                end
                default: begin
                    if (step_q == LAST_STEP) begin
                        step_q <= '0;
                        if (rnd_q == LAST_RND) begin
                            st_q   <= SEQ_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            rnd_q <= rnd_q + RND_W'(1);
                        end
                    end else begin
                        step_q <= step_q + STEP_W'(1);
                    end
                end
            endcase
        end
    end

    // Independent count of steps since the last load, for the checks below.
    logic [31:0] chk_steps;
    always_ff @(posedge clk) begin
        if (rst)          chk_steps <= '0;
        else if (load_en) chk_steps <= '0;
        else if (step_en) chk_steps <= chk_steps + 32'd1;
    end

    // R7: done appears only after exactly the configured number of steps
    p_done_count_r7: assert property (@(posedge clk) disable iff (rst)
        done_q |-> chk_steps == 32'(TOTAL_STEPS));

    // R7: no step beyond the configured run
    p_run_bound_r7: assert property (@(posedge clk) disable iff (rst)
        step_en |-> chk_steps < 32'(TOTAL_STEPS));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8: done follows the edge of the final step
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        step_en && last_step |=> done_q && !step_en);

    // R9: start during a run neither reloads nor disturbs the step order
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        step_en && start && !last_step |=> step_en && (step_idx == STEP_W'($past(step_idx) + STEP_W'(1))));

endmodule

// File: rtl/qr_step_core.sv
`timescale 1ns/1ps
module qr_step_core import qrs_pkg::*; #(
    parameter int DBL_ROUNDS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [STATE_W-1:0] load_state,
    output logic               done,
    output logic [STATE_W-1:0] result
);

    logic              load_en;
    logic              step_en;
    logic [STEP_W-1:0] step_idx;
    step_ctl_t         ctl;

    qrs_sequencer #(.DBL_ROUNDS(DBL_ROUNDS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load_en  (load_en),
        .step_en  (step_en),
        .step_idx (step_idx),
        .done     (done)
    );

    qrs_step_rom u_rom (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .step_idx (step_idx),
        .ctl      (ctl)
    );

    qrs_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_vec  (load_state),
        .step_en   (step_en),
        .ctl       (ctl),
        .state_vec (result)
    );

    // R10: the result seen with done stays put unless a new run starts
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> $stable(result));

    // R1: reset leaves done low
    p_reset_done_r1: assert property (@(posedge clk)
        rst |=> !done);

endmodule

// File: tb/qr_step_core_bench.sv
`timescale 1ns/1ps
module qr_step_core_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_a;
    logic         start_b;
    logic [511:0] load_state;
    logic         done_a;
    logic         done_b;
    logic [511:0] res_a;
    logic [511:0] res_b;

    always #2 clk = ~clk;

    qr_step_core u_qr_step_core (
        .clk(clk), .rst(rst), .start(start_a), .load_state(load_state),
        .done(done_a), .result(res_a)
    );

    qr_step_core #(.DBL_ROUNDS(1)) u_qr_step_core_dr1 (
        .clk(clk), .rst(rst), .start(start_b), .load_state(load_state),
        .done(done_b), .result(res_b)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m [16];
    int qa [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
    int qb [8] = '{4, 5, 6, 7, 5, 6, 7, 4};
    int qc [8] = '{8, 9, 10, 11, 10, 11, 8, 9};
    int qd [8] = '{12, 13, 14, 15, 15, 12, 13, 14};

    function automatic logic [31:0] rl(input logic [31:0] v, input int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    task automatic chk(input string req, input string what, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] m_pack();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = m[i];
        return r;
    endfunction

    task automatic model_load(input logic [511:0] v);
        for (int i = 0; i < 16; i++) m[i] = v[i*32 +: 32];
    endtask

    // One element step of the reference, written from the quarter-round form.
    task automatic model_step(input int k);
        int q, a, b, c, d;
        q = (k % 32) / 4;
        a = qa[q]; b = qb[q]; c = qc[q]; d = qd[q];
        case (k % 4)
            0: begin m[a] = m[a] + m[b]; m[d] = rl(m[d] ^ m[a], 16); end
            1: begin m[c] = m[c] + m[d]; m[b] = rl(m[b] ^ m[c], 12); end
            2: begin m[a] = m[a] + m[b]; m[d] = rl(m[d] ^ m[a], 8);  end
            default: begin m[c] = m[c] + m[d]; m[b] = rl(m[b] ^ m[c], 7); end
        endcase
    endtask

    function automatic logic [511:0] pattern(input int p);
        logic [511:0] v;
        logic [31:0]  w;
        v = '0;
        for (int i = 0; i < 16; i++) begin
            case (p)
                0: w = 32'(i + 1);
                1: w = 32'h6170_7865 ^ (32'(i) * 32'h9E37_79B9);
                2, 3, 4, 5: w = (i == (p - 2) * 5) ? (32'h1 << ((p * 7) % 32)) : 32'h0;
                6: w = 32'hFFFF_FFFF;
                default: w = rl(32'hA5C3_0F96, i + 1);
            endcase
            v[i*32 +: 32] = w;
        end
        return v;
    endfunction

    function automatic string step_tag(input int n);
        if (n == 4)  return "R4";
        if (n == 16) return "R5";
        if (n == 32) return "R6";
        return "R3";
    endfunction

    // Pulse start on the full instance; leaves the bench at the negedge after the load edge.
    task automatic begin_run(input int p, input string tag);
        load_state = pattern(p);
        model_load(pattern(p));
        start_a = 1'b1;
        @(posedge clk); @(negedge clk);
        start_a = 1'b0;
        chk(tag, "state after start edge", res_a, m_pack());
    endtask

    // Run 320 steps on the full instance; inj >= 0 pulses start at that step and at the last one.
    task automatic finish_run(input int inj, input string tag);
        for (int k = 0; k < 320; k++) begin
            if (inj >= 0 && (k == inj || k == 319)) begin
                start_a    = 1'b1;
                load_state = pattern(6);
            end
            @(posedge clk); @(negedge clk);
            start_a = 1'b0;
            model_step(k);
            if (k == 318) chk_bit("R8", "done before last step", done_a, 1'b0);
        end
        chk(tag, "final permuted state", res_a, m_pack());
        chk_bit("R8", "done after last step", done_a, 1'b1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        rst        = 1'b1;
        start_a    = 1'b0;
        start_b    = 1'b0;
        load_state = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk_bit("R1", "done after reset", done_a, 1'b0);
        chk("R1", "result after reset", res_a, '0);
        chk_bit("R1", "done after reset dr1", done_b, 1'b0);
        chk("R1", "result after reset dr1", res_b, '0);

        // Stepwise sweep on the one-double-round build: R2..R6, R8
        for (int p = 0; p < 8; p++) begin
            load_state = pattern(p);
            model_load(pattern(p));
            start_b = 1'b1;
            @(posedge clk); @(negedge clk);
            start_b = 1'b0;
            chk("R2", "loaded state", res_b, m_pack());
            for (int k = 0; k < 32; k++) begin
                @(posedge clk); @(negedge clk);
                model_step(k);
                chk(step_tag(k + 1), $sformatf("pattern %0d step %0d", p, k + 1), res_b, m_pack());
                chk_bit("R8", $sformatf("done at step %0d", k + 1), done_b, (k == 31));
            end
            @(posedge clk); @(negedge clk);
            chk_bit("R8", "done falls after one cycle", done_b, 1'b0);
            chk("R10", "idle result hold", res_b, m_pack());
        end

        // R7: full ten-double-round runs, no feed-forward
        begin_run(1, "R2");
        finish_run(-1, "R7");
        @(posedge clk); @(negedge clk);
        chk_bit("R8", "done single cycle", done_a, 1'b0);
        chk("R10", "result held after done", res_a, m_pack());

        // R9: start pulses mid-run and on the final edge are ignored
        begin_run(2, "R2");
        finish_run(100, "R9");

        // R10: start in the done cycle begins a new run
        begin_run(5, "R10");
        finish_run(-1, "R10");
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); @(negedge clk);
        end
        chk("R10", "result after idle cycles", res_a, m_pack());
        chk_bit("R10", "done stays low when idle", done_a, 1'b0);

        report();
        $finish;
    end

endmodule